// File: doc/BRIEF.md
# Registered 14-bit Instruction Decoder

This block turns one 14-bit instruction word into the control bundle that a small 16-bit core needs for one execute step. It names the register-file read and write ports, builds the 16-bit immediate, picks the ALU operation and the write-back source, enables RAM writes, and says which status flags the step updates. It also decides whether a relative branch is taken. For that it uses the zero flag, the carry flag and an equality signal from the register file, all presented in the same cycle as the instruction. The top 4 bits of the word are the opcode. The opcode selects one of four field layouts: register/register, register/constant, memory, and branch.

The decoder samples its inputs on every rising clock edge and holds the decoded bundle in a register. The surrounding core can therefore fetch, decode and execute in step without a long combinational path from instruction memory to the register file. For the compare-and-branch instruction, the branch format has room for only one register field. The second operand is therefore a fixed register chosen by a parameter, the accumulator. Register storage, the ALU, RAM and the program counter sit outside this block.

Top module: `op14_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes zero after that edge.
- R2: Outputs change only at a rising edge, and after edge k they reflect the instruction and flag inputs sampled at edge k.
- R3: Register/register opcodes (0000 add, 0010 subtract, 0110 move) drive read A and write select from bits [9:7] and read B from bits [6:4], ignoring bits [3:0]. They set register write, clear the immediate-operand select and use ALU code add=0, subtract=1, move(pass B)=4.
- R4: Register/constant opcodes (0001 add, 0011 subtract, 0111 move) use bits [9:7] for read A and write select. They zero-extend bits [6:0] onto the 16-bit immediate, set the immediate-operand select, leave read B at 0 and set register write.
- R5: Opcode 0100 (increment, ALU code 2) and 0101 (decrement, ALU code 3) read and write the register at bits [9:7], with read B at 0 and immediate 0.
- R6: Opcode 1000 (load) writes the register at bits [2:0] from RAM (write-back source 1), with read A from bits [9:7] giving the address.
- R7: Opcode 1001 (store) sets RAM write with read A from bits [9:7] (address) and read B from bits [2:0] (data). It sets no register write and no flag update. RAM write and register write are never both high.
- R8: Opcode 1110 is taken when Z is 0, 1101 when C is 1, 1100 when the equality input is 0, and 1111 always. No branch opcode sets register or RAM write.
- R9: Opcode 1100 reads bits [9:7] on read A and the accumulator register (parameter, default 1) on read B. The other three branch opcodes leave both read selects at 0.
- R10: The branch offset output always equals bits [6:0]. For branch opcodes the immediate is bits [6:0] sign-extended to 16 bits.
- R11: Opcodes 1010 and 1011 are no-operations: no register write, RAM write, flag update or branch, with all selects, immediate and ALU code at 0.
- R12: The Z update enable is high exactly when register write is high. The C update enable is high only for add, subtract, increment and decrement.
- R13: Every output other than those named for an opcode stays 0: write-back source 0 (ALU), ALU code 0 and selects 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 14 | Instruction word |
| flag_z_i | input | 1 | Current zero flag |
| flag_c_i | input | 1 | Current carry flag |
| regs_eq_i | input | 1 | High when the two register read ports hold equal values |
| wr_sel_o | output | 3 | Register write select |
| rd_a_sel_o | output | 3 | Register read port A select |
| rd_b_sel_o | output | 3 | Register read port B select |
| imm_o | output | 16 | Extended immediate |
| alu_op_o | output | 3 | ALU operation code |
| wb_src_o | output | 1 | Write-back source: 0 ALU, 1 RAM |
| b_imm_o | output | 1 | ALU operand B taken from the immediate |
| reg_we_o | output | 1 | Register write enable |
| ram_we_o | output | 1 | RAM write enable |
| z_upd_o | output | 1 | Zero flag update enable |
| c_upd_o | output | 1 | Carry flag update enable |
| br_take_o | output | 1 | Branch taken |
| br_off_o | output | 7 | Relative branch offset |

## Verification
The hardest case to reach from the ports is a conditional branch whose flags point the other way. Each of the three conditional opcodes is driven twice, once with the deciding input set to take the branch and once set to fall through, while the unrelated flags are set to values that would mislead a decoder reading the wrong one. Reset is also raised in the same cycle as an unconditional jump, to show that the synchronous reset wins over an instruction already presented. The one-cycle latency is checked by changing the instruction between edges and reading the outputs before the next edge.

// File: rtl/op14_pkg.sv
package op14_pkg;

  localparam int OPC_W   = 4;
  localparam int RSEL_W  = 3;
  localparam int FLD_W   = 7;
  localparam int INSTR_W = OPC_W + RSEL_W + FLD_W;
  localparam int LOW_W   = FLD_W - RSEL_W;

  localparam logic [OPC_W-1:0] OP_ADD_RR = 4'b0000;
  localparam logic [OPC_W-1:0] OP_ADD_RI = 4'b0001;
  localparam logic [OPC_W-1:0] OP_SUB_RR = 4'b0010;
  localparam logic [OPC_W-1:0] OP_SUB_RI = 4'b0011;
  localparam logic [OPC_W-1:0] OP_INC    = 4'b0100;
  localparam logic [OPC_W-1:0] OP_DEC    = 4'b0101;
  localparam logic [OPC_W-1:0] OP_MOV_RR = 4'b0110;
  localparam logic [OPC_W-1:0] OP_MOV_RI = 4'b0111;
  localparam logic [OPC_W-1:0] OP_LOAD   = 4'b1000;
  localparam logic [OPC_W-1:0] OP_STORE  = 4'b1001;
  localparam logic [OPC_W-1:0] OP_CJNE   = 4'b1100;
  localparam logic [OPC_W-1:0] OP_JC     = 4'b1101;
  localparam logic [OPC_W-1:0] OP_JNZ    = 4'b1110;
  localparam logic [OPC_W-1:0] OP_JMP    = 4'b1111;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_INC  = 3'd2,
    ALU_DEC  = 3'd3,
    ALU_PASS = 3'd4
  } alu_op_e;

  typedef enum logic {
    WB_ALU = 1'b0,
    WB_RAM = 1'b1
  } wb_src_e;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_ZERO = 2'd1,
    IMM_SIGN = 2'd2
  } imm_kind_e;

  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_NZ     = 3'd1,
    BC_CARRY  = 3'd2,
    BC_NE     = 3'd3,
    BC_ALWAYS = 3'd4
  } br_cond_e;

  typedef struct packed {
    logic [RSEL_W-1:0] wsel;
    logic [RSEL_W-1:0] asel;
    logic [RSEL_W-1:0] bsel;
    alu_op_e           alu;
    wb_src_e           wb;
    logic              b_imm;
    logic              reg_we;
    logic              ram_we;
    logic              z_upd;
    logic              c_upd;
    imm_kind_e         imm_kind;
    br_cond_e          cond;
  } ctrl_t;

endpackage

// File: rtl/op14_fields.sv
module op14_fields
  import op14_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [OPC_W-1:0]   opc,
  output logic [RSEL_W-1:0]  r_hi,
  output logic [RSEL_W-1:0]  r_mid,
  output logic [RSEL_W-1:0]  r_lo,
  output logic [FLD_W-1:0]   fld
);
  localparam int HI_LSB  = FLD_W;
  localparam int MID_LSB = FLD_W - RSEL_W;

  assign opc   = instr[INSTR_W-1 -: OPC_W];
  assign r_hi  = instr[HI_LSB +: RSEL_W];
  assign r_mid = instr[MID_LSB +: RSEL_W];
  assign r_lo  = instr[0 +: RSEL_W];
  assign fld   = instr[0 +: FLD_W];
endmodule

// File: rtl/op14_ctrl.sv
module op14_ctrl
  import op14_pkg::*;
#(
  parameter int ACC_IDX = 1
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [RSEL_W-1:0] r_hi,
  input  logic [RSEL_W-1:0] r_mid,
  input  logic [RSEL_W-1:0] r_lo,
  output ctrl_t             ctrl
);
  localparam logic [RSEL_W-1:0] ACC_SEL = RSEL_W'(ACC_IDX);

  always_comb begin
    ctrl = '0;
    case (opc)
      OP_ADD_RR, OP_SUB_RR, OP_MOV_RR: begin
        ctrl.wsel   = r_hi;
        ctrl.asel   = r_hi;
        ctrl.bsel   = r_mid;
        ctrl.reg_we = 1'b1;
        ctrl.z_upd  = 1'b1;
        ctrl.c_upd  = (opc != OP_MOV_RR);
        ctrl.alu    = (opc == OP_ADD_RR) ? ALU_ADD :
                      (opc == OP_SUB_RR) ? ALU_SUB : ALU_PASS;
      end
      OP_ADD_RI, OP_SUB_RI, OP_MOV_RI: begin
        ctrl.wsel     = r_hi;
        ctrl.asel     = r_hi;
        ctrl.b_imm    = 1'b1;
        ctrl.imm_kind = IMM_ZERO;
        ctrl.reg_we   = 1'b1;
        ctrl.z_upd    = 1'b1;
        ctrl.c_upd    = (opc != OP_MOV_RI);
        ctrl.alu      = (opc == OP_ADD_RI) ? ALU_ADD :
                        (opc == OP_SUB_RI) ? ALU_SUB : ALU_PASS;
      end
      OP_INC, OP_DEC: begin
        ctrl.wsel   = r_hi;
        ctrl.asel   = r_hi;
        ctrl.reg_we = 1'b1;
        ctrl.z_upd  = 1'b1;
        ctrl.c_upd  = 1'b1;
        ctrl.alu    = (opc == OP_INC) ? ALU_INC : ALU_DEC;
      end
      OP_LOAD: begin
        ctrl.wsel   = r_lo;
        ctrl.asel   = r_hi;
        ctrl.wb     = WB_RAM;
        ctrl.reg_we = 1'b1;
        ctrl.z_upd  = 1'b1;
      end
      OP_STORE: begin
        ctrl.asel   = r_hi;
        ctrl.bsel   = r_lo;
        ctrl.ram_we = 1'b1;
      end
      OP_CJNE: begin
        ctrl.asel     = r_hi;
        ctrl.bsel     = ACC_SEL;
        ctrl.imm_kind = IMM_SIGN;
        ctrl.cond     = BC_NE;
      end
      OP_JC: begin
        ctrl.imm_kind = IMM_SIGN;
        ctrl.cond     = BC_CARRY;
      end
      OP_JNZ: begin
        ctrl.imm_kind = IMM_SIGN;
        ctrl.cond     = BC_NZ;
      end
      OP_JMP: begin
        ctrl.imm_kind = IMM_SIGN;
        ctrl.cond     = BC_ALWAYS;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/op14_cond_imm.sv
module op14_cond_imm
  import op14_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  br_cond_e          cond,
  input  imm_kind_e         kind,
  input  logic [FLD_W-1:0]  fld,
  input  logic              z,
  input  logic              c,
  input  logic              eq,
  output logic              take,
  output logic [DATA_W-1:0] imm
);
  localparam int EXT_W = DATA_W - FLD_W;

  always_comb begin
    case (cond)
      BC_NZ:     take = ~z;
      BC_CARRY:  take = c;
      BC_NE:     take = ~eq;
      BC_ALWAYS: take = 1'b1;
      default:   take = 1'b0;
    endcase
  end

  always_comb begin
    case (kind)
      IMM_ZERO: imm = {{EXT_W{1'b0}}, fld};
      IMM_SIGN: imm = {{EXT_W{fld[FLD_W-1]}}, fld};
      default:  imm = '0;
    endcase
  end
endmodule

// File: rtl/op14_decoder.sv
module op14_decoder
  import op14_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ACC_IDX = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [13:0]         instr_i,
  input  logic                flag_z_i,
  input  logic                flag_c_i,
  input  logic                regs_eq_i,
  output logic [2:0]          wr_sel_o,
  output logic [2:0]          rd_a_sel_o,
  output logic [2:0]          rd_b_sel_o,
  output logic [DATA_W-1:0]   imm_o,
  output logic [2:0]          alu_op_o,
  output logic                wb_src_o,
  output logic                b_imm_o,
  output logic                reg_we_o,
  output logic                ram_we_o,
  output logic                z_upd_o,
  output logic                c_upd_o,
  output logic                br_take_o,
  output logic [6:0]          br_off_o
);
  logic [OPC_W-1:0]  opc;
  logic [RSEL_W-1:0] r_hi, r_mid, r_lo;
  logic [FLD_W-1:0]  fld;
  ctrl_t             ctrl;
  logic              take_c;
  logic [DATA_W-1:0] imm_c;

  op14_fields u_fields (
    .instr (instr_i),
    .opc   (opc),
    .r_hi  (r_hi),
    .r_mid (r_mid),
    .r_lo  (r_lo),
    .fld   (fld)
  );

  op14_ctrl #(.ACC_IDX(ACC_IDX)) u_ctrl (
    .opc   (opc),
    .r_hi  (r_hi),
    .r_mid (r_mid),
    .r_lo  (r_lo),
    .ctrl  (ctrl)
  );

  op14_cond_imm #(.DATA_W(DATA_W)) u_cond (
    .cond (ctrl.cond),
    .kind (ctrl.imm_kind),
    .fld  (fld),
    .z    (flag_z_i),
    .c    (flag_c_i),
    .eq   (regs_eq_i),
    .take (take_c),
    .imm  (imm_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel_o   <= '0;
      rd_a_sel_o <= '0;
      rd_b_sel_o <= '0;
      imm_o      <= '0;
      alu_op_o   <= '0;
      wb_src_o   <= 1'b0;
      b_imm_o    <= 1'b0;
      reg_we_o   <= 1'b0;
      ram_we_o   <= 1'b0;
      z_upd_o    <= 1'b0;
      c_upd_o    <= 1'b0;
      br_take_o  <= 1'b0;
      br_off_o   <= '0;
    end else begin
      wr_sel_o   <= ctrl.wsel;
      rd_a_sel_o <= ctrl.asel;
      rd_b_sel_o <= ctrl.bsel;
      imm_o      <= imm_c;
      alu_op_o   <= ctrl.alu;
      wb_src_o   <= ctrl.wb;
      b_imm_o    <= ctrl.b_imm;
      reg_we_o   <= ctrl.reg_we;
      ram_we_o   <= ctrl.ram_we;
      z_upd_o    <= ctrl.z_upd;
      c_upd_o    <= ctrl.c_upd;
      br_take_o  <= take_c;
      br_off_o   <= fld;
    end
  end
endmodule

// File: rtl/op14_decoder_chk.sv
module op14_decoder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [13:0]       instr_i,
  input logic              flag_z_i,
  input logic              flag_c_i,
  input logic              regs_eq_i,
  input logic [2:0]        wr_sel_o,
  input logic [2:0]        rd_a_sel_o,
  input logic [2:0]        rd_b_sel_o,
  input logic [DATA_W-1:0] imm_o,
  input logic [2:0]        alu_op_o,
  input logic              wb_src_o,
  input logic              b_imm_o,
  input logic              reg_we_o,
  input logic              ram_we_o,
  input logic              z_upd_o,
  input logic              c_upd_o,
  input logic              br_take_o,
  input logic [6:0]        br_off_o
);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!reg_we_o && !ram_we_o && !br_take_o && !z_upd_o && !c_upd_o
                    && imm_o == '0 && br_off_o == '0 && wr_sel_o == '0));

  p_off_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> br_off_o == $past(instr_i[6:0]));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[13:10]) == 4'b1000)
      |-> (reg_we_o && wb_src_o && wr_sel_o == $past(instr_i[2:0])
           && rd_a_sel_o == $past(instr_i[9:7])));

  p_store_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[13:10]) == 4'b1001)
      |-> (ram_we_o && !reg_we_o && !z_upd_o && !c_upd_o
           && rd_b_sel_o == $past(instr_i[2:0])));

  p_we_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(reg_we_o && ram_we_o));

  p_jmp_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[13:10]) == 4'b1111) |-> br_take_o);

  p_jnz_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[13:10]) == 4'b1110) |-> (br_take_o == !$past(flag_z_i)));

  p_jc_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[13:10]) == 4'b1101) |-> (br_take_o == $past(flag_c_i)));

  p_cjne_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[13:10]) == 4'b1100) |-> (br_take_o == !$past(regs_eq_i)));

  p_br_nowr_r8: assert property (@(posedge clk) disable iff (rst)
    br_take_o |-> (!reg_we_o && !ram_we_o));

  p_nop_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[13:11]) == 3'b101)
      |-> (!reg_we_o && !ram_we_o && !z_upd_o && !c_upd_o && !br_take_o));

  p_zupd_r12: assert property (@(posedge clk) disable iff (rst)
    z_upd_o == reg_we_o);

  p_cupd_r12: assert property (@(posedge clk) disable iff (rst)
    c_upd_o |-> z_upd_o);

endmodule

bind op14_decoder op14_decoder_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/op14_decoder_tb_top.sv
module op14_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] instr_i = '0;
  logic        flag_z_i = 1'b0;
  logic        flag_c_i = 1'b0;
  logic        regs_eq_i = 1'b0;
  logic [2:0]  wr_sel_o, rd_a_sel_o, rd_b_sel_o, alu_op_o;
  logic [15:0] imm_o;
  logic        wb_src_o, b_imm_o, reg_we_o, ram_we_o, z_upd_o, c_upd_o, br_take_o;
  logic [6:0]  br_off_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  op14_decoder dut_i (
    .clk        (clk),
    .rst        (rst),
    .instr_i    (instr_i),
    .flag_z_i   (flag_z_i),
    .flag_c_i   (flag_c_i),
    .regs_eq_i  (regs_eq_i),
    .wr_sel_o   (wr_sel_o),
    .rd_a_sel_o (rd_a_sel_o),
    .rd_b_sel_o (rd_b_sel_o),
    .imm_o      (imm_o),
    .alu_op_o   (alu_op_o),
    .wb_src_o   (wb_src_o),
    .b_imm_o    (b_imm_o),
    .reg_we_o   (reg_we_o),
    .ram_we_o   (ram_we_o),
    .z_upd_o    (z_upd_o),
    .c_upd_o    (c_upd_o),
    .br_take_o  (br_take_o),
    .br_off_o   (br_off_o)
  );

  typedef struct packed {
    logic [13:0] ins;
    logic        z, c, eq;
    logic [2:0]  w, a, b;
    logic [15:0] imm;
    logic [2:0]  alu;
    logic        wb, bi, rwe, mwe, zu, cu, bt;
    logic [6:0]  off;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R3 add R3,R5
    '{{4'b0000,3'd3,3'd5,4'd0}, 1'b0,1'b0,1'b0, 3'd3,3'd3,3'd5, 16'h0000, 3'd0, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 7'h50, 8'd3},
    // R3 sub R7,R0 with junk in ignored bits
    '{{4'b0010,3'd7,3'd0,4'hF}, 1'b1,1'b1,1'b1, 3'd7,3'd7,3'd0, 16'h0000, 3'd1, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 7'h0F, 8'd3},
    // R3 R12 move R1,R6: Z only
    '{{4'b0110,3'd1,3'd6,4'd0}, 1'b0,1'b0,1'b0, 3'd1,3'd1,3'd6, 16'h0000, 3'd4, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 7'h60, 8'd3},
    // R4 add R2,#127 zero-extended
    '{{4'b0001,3'd2,7'h7F}, 1'b0,1'b0,1'b0, 3'd2,3'd2,3'd0, 16'h007F, 3'd0, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 7'h7F, 8'd4},
    // R4 sub R4,#5
    '{{4'b0011,3'd4,7'd5}, 1'b0,1'b0,1'b0, 3'd4,3'd4,3'd0, 16'h0005, 3'd1, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 7'h05, 8'd4},
    // R4 R12 move R6,#64
    '{{4'b0111,3'd6,7'h40}, 1'b0,1'b0,1'b0, 3'd6,3'd6,3'd0, 16'h0040, 3'd4, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 7'h40, 8'd4},
    // R5 inc R5
    '{{4'b0100,3'd5,7'h2A}, 1'b0,1'b0,1'b0, 3'd5,3'd5,3'd0, 16'h0000, 3'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 7'h2A, 8'd5},
    // R5 dec R2
    '{{4'b0101,3'd2,7'h00}, 1'b1,1'b0,1'b0, 3'd2,3'd2,3'd0, 16'h0000, 3'd3, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 7'h00, 8'd5},
    // R6 load R6 from address in R7
    '{{4'b1000,3'd7,4'd0,3'd6}, 1'b0,1'b0,1'b0, 3'd6,3'd7,3'd0, 16'h0000, 3'd0, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 7'h06, 8'd6},
    // R7 store R4 to address in R2
    '{{4'b1001,3'd2,4'd0,3'd4}, 1'b0,1'b0,1'b0, 3'd0,3'd2,3'd4, 16'h0000, 3'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 7'h04, 8'd7},
    // R8 R10 jnz -2, Z=0 taken
    '{{4'b1110,3'd0,7'h7E}, 1'b0,1'b1,1'b1, 3'd0,3'd0,3'd0, 16'hFFFE, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 7'h7E, 8'd8},
    // R8 jnz, Z=1 not taken
    '{{4'b1110,3'd0,7'h7E}, 1'b1,1'b0,1'b0, 3'd0,3'd0,3'd0, 16'hFFFE, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h7E, 8'd8},
    // R8 R10 jc +4, C=1 taken
    '{{4'b1101,3'd0,7'd4}, 1'b1,1'b1,1'b1, 3'd0,3'd0,3'd0, 16'h0004, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 7'h04, 8'd8},
    // R8 jc, C=0 not taken
    '{{4'b1101,3'd0,7'd4}, 1'b0,1'b0,1'b0, 3'd0,3'd0,3'd0, 16'h0004, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h04, 8'd8},
    // R9 cjne R3 vs accumulator, unequal: taken
    '{{4'b1100,3'd3,7'h7D}, 1'b1,1'b0,1'b0, 3'd0,3'd3,3'd1, 16'hFFFD, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 7'h7D, 8'd9},
    // R9 cjne equal: not taken
    '{{4'b1100,3'd3,7'h7D}, 1'b0,1'b1,1'b1, 3'd0,3'd3,3'd1, 16'hFFFD, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h7D, 8'd9},
    // R8 R10 jmp with misleading flags
    '{{4'b1111,3'd5,7'h40}, 1'b1,1'b0,1'b1, 3'd0,3'd0,3'd0, 16'hFFC0, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 7'h40, 8'd8},
    // R11 R13 opcode 1010 no-op
    '{{4'b1010,10'h3FF}, 1'b0,1'b1,1'b0, 3'd0,3'd0,3'd0, 16'h0000, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h7F, 8'd11},
    // R11 opcode 1011 no-op
    '{{4'b1011,10'h155}, 1'b0,1'b1,1'b0, 3'd0,3'd0,3'd0, 16'h0000, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h55, 8'd11}
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(input vec_t v);
    chk("wr_sel",  v.req, 32'(wr_sel_o),   32'(v.w));
    chk("rd_a",    v.req, 32'(rd_a_sel_o), 32'(v.a));
    chk("rd_b",    v.req, 32'(rd_b_sel_o), 32'(v.b));
    chk("imm",     v.req, 32'(imm_o),      32'(v.imm));
    chk("alu_op",  v.req, 32'(alu_op_o),   32'(v.alu));
    chk("wb_src",  v.req, 32'(wb_src_o),   32'(v.wb));
    chk("b_imm",   v.req, 32'(b_imm_o),    32'(v.bi));
    chk("reg_we",  v.req, 32'(reg_we_o),   32'(v.rwe));
    chk("ram_we",  v.req, 32'(ram_we_o),   32'(v.mwe));
    chk("z_upd",   v.req, 32'(z_upd_o),    32'(v.zu));
    chk("c_upd",   v.req, 32'(c_upd_o),    32'(v.cu));
    chk("br_take", v.req, 32'(br_take_o),  32'(v.bt));
    chk("br_off",  v.req, 32'(br_off_o),   32'(v.off));
  endtask

  task automatic chk_zero(input int req);
    vec_t z = '0;
    z.req = 8'(req);
    chk_vec(z);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with a live instruction on the input
    @(negedge clk);
    instr_i = {4'b0111, 3'd5, 7'h33};
    flag_z_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_zero(1);

    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      instr_i   = VECS[i].ins;
      flag_z_i  = VECS[i].z;
      flag_c_i  = VECS[i].c;
      regs_eq_i = VECS[i].eq;
      @(negedge clk);
      chk_vec(VECS[i]);
    end

    // R2: new input between edges does not reach the outputs early
    instr_i = {4'b0000, 3'd2, 3'd4, 4'd0};
    @(negedge clk);
    instr_i = {4'b1001, 3'd6, 4'd0, 3'd1};
    #1;
    chk("R2 hold reg_we", 2, 32'(reg_we_o), 32'd1);
    chk("R2 hold ram_we", 2, 32'(ram_we_o), 32'd0);
    chk("R2 hold wr_sel", 2, 32'(wr_sel_o), 32'd2);
    @(negedge clk);
    chk("R2 update ram_we", 2, 32'(ram_we_o), 32'd1);
    chk("R2 update rd_b",   2, 32'(rd_b_sel_o), 32'd1);
    chk("R2 update reg_we", 2, 32'(reg_we_o), 32'd0);

    // R8: flag change alone after the instruction edge is not seen until next edge
    instr_i  = {4'b1110, 3'd0, 7'h03};
    flag_z_i = 1'b0;
    @(negedge clk);
    flag_z_i = 1'b1;
    #1;
    chk("R8 jnz held", 8, 32'(br_take_o), 32'd1);
    @(negedge clk);
    chk("R8 jnz resampled", 8, 32'(br_take_o), 32'd0);

    // R1: reset raised together with an unconditional jump
    instr_i = {4'b1111, 3'd0, 7'h11};
    rst = 1'b1;
    @(negedge clk);
    chk_zero(1);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 jmp after reset", 8, 32'(br_take_o), 32'd1);
    chk("R10 off after reset", 10, 32'(br_off_o), 32'h11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule